// File: doc/BRIEF.md
# DRAM Temperature Polling Scheduler

This block sits beside a memory controller's command arbiter and keeps software informed of the DRAM's thermal state. While enabled, it waits a programmable interval, then asks the arbiter to issue a read of the DRAM's temperature/refresh mode register. The returned byte is decoded into a refresh-rate code, a thermal-offset field, a hot flag and a signed interval exponent. These values are held in status outputs. The block itself never touches refresh timing.

If the arbiter leaves the request waiting, the block raises it from normal to high priority after a second count. After a third count it flags a timeout, and keeps the request up until it is granted. All intervals are measured in long ticks. One long tick is `cfg_prescale + 1` core clock cycles. A count of zero is treated as one tick.

Each completed read is compared with the previously captured rate code. A difference sets a sticky interrupt, and the first read after reset always does so. An interrupt service routine then clears the interrupt and reprograms the refresh interval.

Top module: `dram_temp_poller`

## Requirements
- R1: While `poll_en` is 0, `req_valid` is 0 from the next cycle on, and no interval counting takes place.
- R2: After the first enabled cycle, or after the cycle a read completes, `req_valid` rises exactly max(`cfg_poll_cnt`,1)·(`cfg_prescale`+1) cycles later.
- R3: An ungranted request raises `req_high` exactly max(`cfg_high_cnt`,1)·(`cfg_prescale`+1) cycles after `req_valid` rose. `req_high` is only ever 1 together with `req_valid`.
- R4: If the request is still ungranted, `stat_timeout` rises max(`cfg_tmo_cnt`,1)·(`cfg_prescale`+1) cycles after `req_high` rose. The request stays asserted. `stat_timeout` stays 1 until a read completes, and that read clears it.
- R5: A cycle with `req_grant` and `req_valid` both 1 drops `req_valid` and `req_high` in the next cycle. The read then stays outstanding, with no new request, until `rd_valid` arrives.
- R6: A `rd_valid` pulse with no read outstanding is ignored. The status outputs and `irq` keep their values.
- R7: On a completed read, `stat_code` takes `rd_data[2:0]` and `stat_offset` takes `rd_data[6:5]`. `stat_hot` equals `rd_data[2]`, meaning above the nominal 85 °C point.
- R8: `stat_ivl_exp` is the base-2 refresh-interval exponent, in two's complement:
  - code 1 gives +2, code 2 gives +1, and code 3 gives 0 (nominal);
  - code 4 gives −1, and codes 5, 6 and 7 give −2;
  - code 0 gives 0 and sets `stat_invalid`;
  - code 6 sets `stat_derate`, and code 7 sets `stat_limit`.
- R9: `irq` is set by a completed read whose code differs from the previously captured code. The first completed read after reset always sets it.
- R10: `irq` stays 1 until a cycle with `irq_clr` = 1 clears it. When a setting read and `irq_clr` coincide, `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_en | input | 1 | Enables periodic polling |
| cfg_prescale | input | PW (8) | Long tick length minus one, in clock cycles |
| cfg_poll_cnt | input | CW (8) | Long ticks between a completed read and the next request |
| cfg_high_cnt | input | CW (8) | Long ticks at normal priority before escalation |
| cfg_tmo_cnt | input | CW (8) | Long ticks at high priority before timeout |
| req_valid | output | 1 | Mode-register read request to the arbiter |
| req_high | output | 1 | Request carries high priority |
| req_grant | input | 1 | Arbiter accepts the request |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | DW (8) | Returned mode-register value |
| irq | output | 1 | Sticky temperature-change interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| stat_code | output | 3 | Captured refresh-rate code |
| stat_offset | output | 2 | Captured thermal offset field |
| stat_hot | output | 1 | Device above nominal temperature |
| stat_ivl_exp | output | 3 | Signed refresh-interval exponent |
| stat_derate | output | 1 | Code demands derating |
| stat_limit | output | 1 | Code is the high-temperature limit |
| stat_invalid | output | 1 | Code is invalid |
| stat_timeout | output | 1 | Request escalated past its timeout |

## Verification
Three things are hard to reach from the ports:
- the timeout window, which needs a request held ungranted through two full escalation phases under some prescaler setting;
- an interrupt set and a clear arriving in the same cycle;
- a stray read strobe landing while the interval counter runs.

The bench gets there by drawing the prescaler, all three counts (zero included), the grant point (immediate, after escalation, or after timeout) and the returned byte from `$urandom` with a fixed seed. Into the idle window it injects stray strobes and clear pulses, on top of directed cases for the first read, repeated codes and a coinciding set and clear.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_NORM = 2'd1,
    PH_HIGH = 2'd2,
    PH_WAIT = 2'd3
  } phase_e;

  typedef struct packed {
    logic [2:0] code;
    logic [1:0] offset;
    logic       hot;
    logic [2:0] ivl_exp;
    logic       derate;
    logic       limit;
    logic       invalid;
  } temp_rep_t;

  // Base-2 exponent of the refresh interval relative to nominal.
  function automatic logic [2:0] ivl_exp_of(input logic [2:0] code);
    logic [2:0] e;
    case (code)
      3'd1:    e = 3'sd2;
      3'd2:    e = 3'sd1;
      3'd4:    e = -3'sd1;
      3'd5,
      3'd6,
      3'd7:    e = -3'sd2;
      default: e = 3'sd0;
    endcase
    return e;
  endfunction

  function automatic temp_rep_t decode_mr(input logic [7:0] d);
    temp_rep_t r;
    r.code    = d[2:0];
    r.offset  = d[6:5];
    r.hot     = d[2];
    r.ivl_exp = ivl_exp_of(d[2:0]);
    r.derate  = (d[2:0] == 3'd6);
    r.limit   = (d[2:0] == 3'd7);
    r.invalid = (d[2:0] == 3'd0);
    return r;
  endfunction

endpackage

// File: rtl/dtp_tick.sv
module dtp_tick #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] prescale,
  output logic          tick
);

  logic [PW-1:0] cnt_q;

  assign tick = run && (cnt_q == prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // A stopped prescaler restarts from zero (R1, R2).
  p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/dtp_sched.sv
module dtp_sched
  import dtp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] poll_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic [CW-1:0] tmo_cnt,
  input  logic          grant,
  input  logic          rd_valid,
  output logic          run,
  output logic          restart,
  output logic          req_valid,
  output logic          req_high,
  output logic          timeout,
  output logic          outstanding,
  output logic          rd_accept
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] ticks_q;
  logic [CW-1:0] limit_raw;
  logic [CW-1:0] limit_eff;
  logic          phase_done;
  logic          tmo_set;

  always_comb begin
    case (ph_q)
      PH_IDLE: limit_raw = poll_cnt;
      PH_NORM: limit_raw = high_cnt;
      PH_HIGH: limit_raw = tmo_cnt;
      default: limit_raw = '0;
    endcase
  end

  assign limit_eff   = (limit_raw == '0) ? CW'(1) : limit_raw;
  assign phase_done  = tick && (ticks_q == limit_eff - 1'b1);
  assign outstanding = (ph_q == PH_WAIT);
  assign rd_accept   = outstanding && rd_valid;
  assign req_valid   = (ph_q == PH_NORM) || (ph_q == PH_HIGH);
  assign req_high    = (ph_q == PH_HIGH);
  assign run         = en && ((ph_q == PH_IDLE) || (ph_q == PH_NORM) ||
                              ((ph_q == PH_HIGH) && !timeout));
  assign tmo_set     = (ph_q == PH_HIGH) && phase_done && !timeout && !grant;

  always_comb begin
    ph_d = ph_q;
    if (!en) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (phase_done) ph_d = PH_NORM;
        PH_NORM: begin
          if (grant)           ph_d = PH_WAIT;
          else if (phase_done) ph_d = PH_HIGH;
        end
        PH_HIGH: if (grant)    ph_d = PH_WAIT;
        PH_WAIT: if (rd_valid) ph_d = PH_IDLE;
        default:               ph_d = PH_IDLE;
      endcase
    end
  end

  assign restart = (ph_d != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      ticks_q <= '0;
      timeout <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (restart || !run) begin
        ticks_q <= '0;
      end else if (tick) begin
        ticks_q <= phase_done ? '0 : ticks_q + 1'b1;
      end
      if (!en || rd_accept) begin
        timeout <= 1'b0;
      end else if (tmo_set) begin
        timeout <= 1'b1;
      end
    end
  end

  p_no_req_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req_valid);

  p_high_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_high |-> req_valid);

  p_grant_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && grant && en) |=> (!req_valid && outstanding));

  p_timeout_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && en && !rd_accept) |=> timeout);

  p_timeout_while_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> req_high);

endmodule

// File: rtl/dtp_capture.sv
module dtp_capture
  import dtp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_accept,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          irq_clr,
  output temp_rep_t     rep,
  output logic          irq
);

  temp_rep_t rep_d;
  logic      seen_q;
  logic      code_change;

  assign rep_d       = decode_mr(rd_data[7:0]);
  assign code_change = rd_accept && (!seen_q || (rep_d.code != rep.code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep    <= '0;
      seen_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (rd_accept) begin
        rep    <= rep_d;
        seen_q <= 1'b1;
      end
      if (code_change) begin
        irq <= 1'b1;
      end else if (irq_clr) begin
        irq <= 1'b0;
      end
    end
  end

  p_ignore_stray_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_accept) |=> $stable(rep));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    code_change |=> irq);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rep.derate, rep.limit, rep.invalid}));

endmodule

// File: rtl/dram_temp_poller.sv
module dram_temp_poller
  import dtp_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_en,
  input  logic [PW-1:0] cfg_prescale,
  input  logic [CW-1:0] cfg_poll_cnt,
  input  logic [CW-1:0] cfg_high_cnt,
  input  logic [CW-1:0] cfg_tmo_cnt,
  output logic          req_valid,
  output logic          req_high,
  input  logic          req_grant,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          irq,
  input  logic          irq_clr,
  output logic [2:0]    stat_code,
  output logic [1:0]    stat_offset,
  output logic          stat_hot,
  output logic [2:0]    stat_ivl_exp,
  output logic          stat_derate,
  output logic          stat_limit,
  output logic          stat_invalid,
  output logic          stat_timeout
);

  logic      tick;
  logic      run;
  logic      restart;
  logic      outstanding;
  logic      rd_accept;
  temp_rep_t rep;

  dtp_tick #(.PW(PW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (restart),
    .prescale (cfg_prescale),
    .tick     (tick)
  );

  dtp_sched #(.CW(CW)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (poll_en),
    .tick        (tick),
    .poll_cnt    (cfg_poll_cnt),
    .high_cnt    (cfg_high_cnt),
    .tmo_cnt     (cfg_tmo_cnt),
    .grant       (req_grant),
    .rd_valid    (rd_valid),
    .run         (run),
    .restart     (restart),
    .req_valid   (req_valid),
    .req_high    (req_high),
    .timeout     (stat_timeout),
    .outstanding (outstanding),
    .rd_accept   (rd_accept)
  );

  dtp_capture #(.DW(DW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_accept (rd_accept),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq_clr   (irq_clr),
    .rep       (rep),
    .irq       (irq)
  );

  assign stat_code    = rep.code;
  assign stat_offset  = rep.offset;
  assign stat_hot     = rep.hot;
  assign stat_ivl_exp = rep.ivl_exp;
  assign stat_derate  = rep.derate;
  assign stat_limit   = rep.limit;
  assign stat_invalid = rep.invalid;

  // Data is taken only while a read is outstanding (R6).
  p_accept_only_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |-> (outstanding && !req_valid));

endmodule

// File: tb/test_dram_temp_poller.sv
module test_dram_temp_poller;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       poll_en;
  logic [7:0] cfg_prescale, cfg_poll_cnt, cfg_high_cnt, cfg_tmo_cnt;
  logic       req_valid, req_high, req_grant;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       irq, irq_clr;
  logic [2:0] stat_code;
  logic [1:0] stat_offset;
  logic       stat_hot;
  logic [2:0] stat_ivl_exp;
  logic       stat_derate, stat_limit, stat_invalid, stat_timeout;

  always #2 clk = ~clk;

  dram_temp_poller i_dram_temp_poller (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
    .cfg_prescale(cfg_prescale), .cfg_poll_cnt(cfg_poll_cnt),
    .cfg_high_cnt(cfg_high_cnt), .cfg_tmo_cnt(cfg_tmo_cnt),
    .req_valid(req_valid), .req_high(req_high), .req_grant(req_grant),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .irq_clr(irq_clr),
    .stat_code(stat_code), .stat_offset(stat_offset), .stat_hot(stat_hot),
    .stat_ivl_exp(stat_ivl_exp), .stat_derate(stat_derate),
    .stat_limit(stat_limit), .stat_invalid(stat_invalid),
    .stat_timeout(stat_timeout)
  );

  int checks = 0;
  int errors = 0;
  logic [2:0] m_code = 3'd0;
  bit         m_seen = 1'b0;
  bit         m_irq  = 1'b0;
  int         cur_p = 0;

  function automatic int span(int n, int p);
    return ((n == 0) ? 1 : n) * (p + 1);
  endfunction

  function automatic int exp_of(int code);
    if (code == 0) return 0;
    if (code <= 3) return 3 - code;
    if (code == 4) return 7;   // -1 in three bits
    return 6;                  // -2 in three bits
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_to(input int sel, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((sel == 0) ? req_valid : (sel == 1) ? req_high : stat_timeout) && n < 4000);
  endtask

  task automatic check_status(string when);
    chk({"R7 code ", when}, stat_code, m_code);
    chk({"R7 hot ", when}, stat_hot, m_code[2]);
    chk({"R8 ivl_exp ", when}, stat_ivl_exp, exp_of(m_code));
    chk({"R8 flags ", when}, {stat_derate, stat_limit, stat_invalid},
        {m_code == 3'd6, m_code == 3'd7, m_code == 3'd0});
    chk({"R9 irq ", when}, irq, m_irq);
  endtask

  // Precondition: a read is outstanding. Completes it, checks the capture,
  // measures the next request, then grants in the chosen phase.
  task automatic complete_read(input logic [7:0] d, input bit clr, input bit noise,
                               input int p, input int n, input int h, input int t,
                               input int mode);
    int cnt;
    bit chg;
    logic [1:0] m_off;
    cfg_prescale = 8'(p); cfg_poll_cnt = 8'(n); cfg_high_cnt = 8'(h); cfg_tmo_cnt = 8'(t);
    rd_valid = 1'b1; rd_data = d; irq_clr = clr;
    @(negedge clk);
    rd_valid = 1'b0; irq_clr = 1'b0;
    chg = !m_seen || (d[2:0] != m_code);
    if (chg) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    m_code = d[2:0]; m_seen = 1'b1; m_off = d[6:5];
    check_status("after read");
    chk("R7 offset", stat_offset, m_off);
    chk("R4 timeout cleared by read", stat_timeout, 0);
    // Wait for the next request; optionally inject a stray strobe and a clear.
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      rd_valid = 1'b0; irq_clr = 1'b0;
      if (noise && span(n, p) >= 4) begin
        if (cnt == 1) begin rd_valid = 1'b1; rd_data = ~d; end
        if (cnt == 2) begin irq_clr = 1'b1; m_irq = 1'b0; end
      end
    end while (!req_valid && cnt < 4000);
    rd_valid = 1'b0; irq_clr = 1'b0;
    chk("R2 poll interval", cnt, span(n, p));
    chk("R6 stray strobe ignored (code)", stat_code, m_code);
    chk("R6 stray strobe ignored (offset)", stat_offset, m_off);
    chk("R10 irq after idle window", irq, m_irq);
    if (mode >= 1) begin
      count_to(1, cnt);
      chk("R3 escalation delay", cnt, span(h, p));
      chk("R3 req held with high", req_valid, 1);
    end
    if (mode >= 2) begin
      count_to(2, cnt);
      chk("R4 timeout delay", cnt, span(t, p));
      repeat (3) @(negedge clk);
      chk("R4 request kept after timeout", {req_valid, req_high, stat_timeout}, 3'b111);
    end
    req_grant = 1'b1;
    @(negedge clk);
    req_grant = 1'b0;
    chk("R5 request dropped on grant", {req_valid, req_high}, 0);
    repeat (span(n, p) + 3) @(negedge clk);
    chk("R5 no new request while outstanding", req_valid, 0);
    chk("R4 timeout held until read", stat_timeout, (mode >= 2) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    bit quiet;
    void'($urandom(32'h0d1e_5eed));
    rst_n = 1'b0; poll_en = 1'b0; req_grant = 1'b0; rd_valid = 1'b0;
    rd_data = 8'h00; irq_clr = 1'b0;
    cfg_prescale = 8'd1; cfg_poll_cnt = 8'd2; cfg_high_cnt = 8'd1; cfg_tmo_cnt = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset req", {req_valid, req_high, stat_timeout, irq}, 0);
    chk("reset status", {stat_code, stat_offset, stat_ivl_exp}, 0);

    // R1: disabled block never requests
    quiet = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (req_valid) quiet = 1'b0;
    end
    chk("R1 no request while disabled", quiet, 1);

    // R2: first request after enable
    poll_en = 1'b1;
    count_to(0, cnt);
    chk("R2 first interval after enable", cnt, span(2, 1));
    req_grant = 1'b1;
    @(negedge clk);
    req_grant = 1'b0;

    // Directed cases
    complete_read(8'h03, 1'b0, 1'b0, 1, 2, 2, 1, 0);  // R9 first read always reports
    complete_read(8'h23, 1'b1, 1'b1, 2, 2, 1, 1, 1);  // same code with clear
    complete_read(8'h43, 1'b0, 1'b0, 0, 3, 2, 3, 2);  // no change; timeout path
    complete_read(8'h65, 1'b1, 1'b0, 0, 1, 1, 1, 0);  // R10 set wins over clear
    complete_read(8'h00, 1'b0, 1'b1, 0, 0, 0, 0, 2);  // invalid code, zero counts
    complete_read(8'h07, 1'b1, 1'b0, 3, 1, 0, 2, 1);  // limit code
    complete_read(8'h06, 1'b0, 1'b1, 1, 4, 1, 1, 0);  // derate code

    // Random sweep
    for (int i = 0; i < 40; i++) begin
      complete_read(8'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
                    int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 2)));
    end

    // R1: disabling an outstanding read returns to idle, no request while off
    poll_en = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (req_valid) quiet = 1'b0;
    end
    chk("R1 no request after disable", quiet, 1);
    cfg_prescale = 8'd0; cfg_poll_cnt = 8'd3;
    poll_en = 1'b1;
    count_to(0, cnt);
    chk("R2 interval after re-enable", cnt, span(3, 0));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule